// File: doc/BRIEF.md
# Transmit Descriptor Ring Tracker

This block keeps the host-side record of a circular ring of transmit descriptors. Each slot holds a 32-bit control word and a 32-bit status word. Bit 31 of the status word is an ownership flag: when it is set, the DMA engine owns the slot. When it is clear, software owns it. A frame is submitted with its length. If the frame is admitted, the block takes the slot at the insert index, writes the control word, gives the slot to the engine and pulses a poll-demand strobe so that the engine fetches the new slot.

The engine returns each slot by writing its status word back with bit 31 clear. On every cycle in which frames are outstanding, the block tries to reclaim the slot at the remove index. Slots are reclaimed strictly in ring order, one per cycle. Reclaim stalls on the first slot that the engine still owns. Every reclaimed status word is inspected. A transmit underrun switches the engine into store-and-forward mode, and that mode then stays on until reset.

The submit side is a valid/ready stream. `sub_ready` is held high, so the block never applies back-pressure and takes one request on each cycle in which `sub_valid` is high. Every request gets exactly one answer one cycle later: either `sub_ok` (accepted) or `sub_err` (refused, with no change of state). The engine reads descriptors through a combinational lookup port.

Top module: `txring_tracker`

## Requirements
- R1: The ring has 16 slots. The insert index and the remove index are 4-bit values that wrap from 15 back to 0. `sub_slot` reports the slot given to the most recent accepted frame.
- R2: A submit is refused (a `sub_err` pulse, no ownership change, no index or count change) when 14 or more frames are already outstanding.
- R3: A submit is refused when its length exceeds 1514. A length of exactly 1514 is accepted.
- R4: In the cycle after an accepted submit, `sub_ok` and `poll_strobe` are high for one cycle each. In the same cycle, the slot's control word reads 0xE1 in bits 31:24 and the length in the low bits, that slot's ownership bit (status bit 31) reads 1, and `inflight` has risen by one.
- R5: A write-back stores `wb_word` as the status word of slot `wb_idx`. While `inflight` is nonzero, one slot per cycle is reclaimed at the remove index if its bit 31 is 0. Each reclaim advances the remove index and lowers `inflight` by one. A returned slot that lies beyond a slot the engine still owns is not reclaimed.
- R6: A reclaimed status word equal to 0x7FFFFFFF counts as a skipped entry. It does not change `sf_mode`, even though bit 1 is set in it.
- R7: A reclaimed status word that has a bit set under mask 0x4302 and also has bit 1 (underrun) set makes `sf_mode` rise. `sf_mode` then stays high until reset.
- R8: A reclaimed status word with errors under mask 0x4302 but with bit 1 clear (for example 0x4000) leaves `sf_mode` unchanged.
- R9: Reset clears both indices, `inflight`, `sf_mode` and every ownership bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sub_valid | input | 1 | Submit request valid |
| sub_ready | output | 1 | Submit ready, held high |
| sub_len | input | 14 | Frame length in bytes |
| sub_ok | output | 1 | One-cycle pulse: previous request accepted |
| sub_err | output | 1 | One-cycle pulse: previous request refused |
| sub_slot | output | 4 | Slot given to the last accepted frame |
| poll_strobe | output | 1 | One-cycle poll-demand pulse to the engine |
| wb_valid | input | 1 | Engine status write-back valid |
| wb_idx | input | 4 | Slot being written back |
| wb_word | input | 32 | Status word written back |
| eng_idx | input | 4 | Slot the engine is reading |
| eng_ctl | output | 32 | Control word of slot `eng_idx` |
| eng_own | output | 1 | Ownership bit of slot `eng_idx` |
| ins_idx | output | 4 | Current insert index |
| rm_idx | output | 4 | Current remove index |
| inflight | output | 5 | Number of outstanding frames |
| sf_mode | output | 1 | Store-and-forward mode request |

## Verification
Some properties are checked on every cycle. The distance between the insert and remove indices always equals the outstanding count. That count never goes past the cap of 14. A refused request never moves the insert index. The two answer pulses never fire together. Once `sf_mode` is set, it stays set. Other behaviour can only be shown by the directed scenarios: the exact control-word contents, the strict in-order stall of reclaim behind an owned slot, the skip value that must not escalate, an error without underrun that must not escalate, and the wrap of the slot index once the ring has been filled.

// File: rtl/txring_pkg.sv
package txring_pkg;
  localparam logic [7:0]  CTL_FLAGS = 8'hE1;
  localparam logic [31:0] SKIP_WORD = 32'h7FFF_FFFF;
  localparam logic [31:0] ERR_MASK  = 32'h0000_4302;
  localparam int          OWN_BIT   = 31;
  localparam int          URUN_BIT  = 1;

  function automatic logic is_underrun(input logic [31:0] st);
    return (st != SKIP_WORD) && ((st & ERR_MASK) != 32'd0) && st[URUN_BIT];
  endfunction
endpackage

// File: rtl/txring_admit.sv
module txring_admit #(
  parameter int LEN_W   = 14,
  parameter int CNT_W   = 5,
  parameter int CAP     = 14,
  parameter int MAX_LEN = 1514
) (
  input  logic             sub_valid,
  input  logic [LEN_W-1:0] sub_len,
  input  logic [CNT_W-1:0] inflight,
  output logic             accept,
  output logic             refuse
);
  logic too_long, full;

  always_comb begin
    too_long = sub_len > LEN_W'(MAX_LEN);
    full     = inflight >= CNT_W'(CAP);
    accept   = sub_valid && !too_long && !full;
    refuse   = sub_valid && (too_long || full);
  end
endmodule

// File: rtl/txring_slots.sv
module txring_slots
  import txring_pkg::*;
#(
  parameter int SLOTS = 16,
  parameter int LEN_W = 14,
  localparam int IDX_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [LEN_W-1:0] set_len,
  input  logic             wb_en,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [31:0]      wb_word,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_ctl,
  output logic             rd_own,
  input  logic [IDX_W-1:0] rm_idx,
  output logic [31:0]      rm_status
);
  logic [31:0] ctl_w [SLOTS];
  logic [31:0] st_w  [SLOTS];

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic [31:0] ctl_q, st_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl_q <= '0;
        st_q  <= '0;
      end else if (set_en && set_idx == IDX_W'(g)) begin
        ctl_q <= {CTL_FLAGS, {(24-LEN_W){1'b0}}, set_len};
        st_q  <= 32'h8000_0000;
      end else if (wb_en && wb_idx == IDX_W'(g)) begin
        st_q  <= wb_word;
      end
    end
    assign ctl_w[g] = ctl_q;
    assign st_w[g]  = st_q;
  end

  assign rd_ctl    = ctl_w[rd_idx];
  assign rd_own    = st_w[rd_idx][OWN_BIT];
  assign rm_status = st_w[rm_idx];
endmodule

// File: rtl/txring_reclaim.sv
module txring_reclaim
  import txring_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pending,
  input  logic [31:0] rm_status,
  output logic        step,
  output logic        sf_mode
);
  assign step = pending && !rm_status[OWN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n)
      sf_mode <= 1'b0;
    else if (step && is_underrun(rm_status) && !sf_mode)
      sf_mode <= 1'b1;
  end

  // R7
  sf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sf_mode |=> sf_mode);
endmodule

// File: rtl/txring_tracker.sv
module txring_tracker #(
  parameter int SLOTS   = 16,
  parameter int CAP     = 14,
  parameter int MAX_LEN = 1514,
  parameter int LEN_W   = 14,
  localparam int IDX_W  = $clog2(SLOTS),
  localparam int CNT_W  = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sub_valid,
  output logic             sub_ready,
  input  logic [LEN_W-1:0] sub_len,
  output logic             sub_ok,
  output logic             sub_err,
  output logic [IDX_W-1:0] sub_slot,
  output logic             poll_strobe,
  input  logic             wb_valid,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic [31:0]      wb_word,
  input  logic [IDX_W-1:0] eng_idx,
  output logic [31:0]      eng_ctl,
  output logic             eng_own,
  output logic [IDX_W-1:0] ins_idx,
  output logic [IDX_W-1:0] rm_idx,
  output logic [CNT_W-1:0] inflight,
  output logic             sf_mode
);
  logic [IDX_W-1:0] ins_q, rm_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept, refuse, step;
  logic [31:0]      rm_status;

  assign sub_ready = 1'b1;

  txring_admit #(.LEN_W(LEN_W), .CNT_W(CNT_W), .CAP(CAP), .MAX_LEN(MAX_LEN)) u_admit (
    .sub_valid(sub_valid), .sub_len(sub_len), .inflight(cnt_q),
    .accept(accept), .refuse(refuse));

  txring_slots #(.SLOTS(SLOTS), .LEN_W(LEN_W)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .set_en(accept), .set_idx(ins_q), .set_len(sub_len),
    .wb_en(wb_valid), .wb_idx(wb_idx), .wb_word(wb_word),
    .rd_idx(eng_idx), .rd_ctl(eng_ctl), .rd_own(eng_own),
    .rm_idx(rm_q), .rm_status(rm_status));

  txring_reclaim u_reclaim (
    .clk(clk), .rst_n(rst_n), .pending(cnt_q != '0),
    .rm_status(rm_status), .step(step), .sf_mode(sf_mode));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ins_q       <= '0;
      rm_q        <= '0;
      cnt_q       <= '0;
      sub_ok      <= 1'b0;
      sub_err     <= 1'b0;
      poll_strobe <= 1'b0;
      sub_slot    <= '0;
    end else begin
      sub_ok      <= accept;
      sub_err     <= refuse;
      poll_strobe <= accept;
      if (accept) begin
        sub_slot <= ins_q;
        ins_q    <= ins_q + 1'b1;
      end
      if (step) rm_q <= rm_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(accept) - CNT_W'(step);
    end
  end

  assign ins_idx  = ins_q;
  assign rm_idx   = rm_q;
  assign inflight = cnt_q;

  // R1
  ptr_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    IDX_W'(ins_q - rm_q) == cnt_q[IDX_W-1:0]);
  // R2
  cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CAP));
  // R3
  reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sub_valid && !accept) |=> ins_q == $past(ins_q));
  // R4
  ok_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sub_ok, sub_err}));
endmodule

// File: tb/sim_txring_tracker.sv
module sim_txring_tracker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sub_valid = 1'b0, sub_ready, sub_ok, sub_err, poll_strobe;
  logic [13:0] sub_len = '0;
  logic [3:0] sub_slot, wb_idx = '0, eng_idx = '0, ins_idx, rm_idx;
  logic wb_valid = 1'b0, eng_own, sf_mode;
  logic [31:0] wb_word = '0, eng_ctl;
  logic [4:0] inflight;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  txring_tracker u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic submit(input logic [13:0] len);
    @(negedge clk);
    sub_valid = 1'b1; sub_len = len;
    @(negedge clk);
    sub_valid = 1'b0;
  endtask

  task automatic writeback(input logic [3:0] idx, input logic [31:0] w);
    @(negedge clk);
    wb_valid = 1'b1; wb_idx = idx; wb_word = w;
    @(negedge clk);
    wb_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    idle(2); rst_n = 1'b1;
  endtask

  task automatic t_reset();
    chk("R9 inflight", 32'(inflight), 0);
    chk("R9 sf_mode", 32'(sf_mode), 0);
    chk("R9 ins_idx", 32'(ins_idx), 0);
    chk("R9 rm_idx", 32'(rm_idx), 0);
    for (int i = 0; i < 16; i++) begin
      eng_idx = 4'(i); #1;
      chk("R9 own clear", 32'(eng_own), 0);
    end
  endtask

  task automatic t_basic();
    submit(14'd64);
    chk("R4 sub_ok", 32'(sub_ok), 1);
    chk("R4 poll", 32'(poll_strobe), 1);
    chk("R1 sub_slot", 32'(sub_slot), 0);
    eng_idx = 4'd0; #1;
    chk("R4 ctl word", eng_ctl, 32'hE100_0040);
    chk("R4 own", 32'(eng_own), 1);
    chk("R4 inflight", 32'(inflight), 1);
    idle(1);
    chk("R4 poll single", 32'(poll_strobe), 0);
  endtask

  task automatic t_length();
    submit(14'd1515);
    chk("R3 refuse long", 32'(sub_err), 1);
    chk("R3 no ok", 32'(sub_ok), 0);
    chk("R3 ins held", 32'(ins_idx), 1);
    chk("R3 inflight held", 32'(inflight), 1);
    submit(14'd1514);
    chk("R3 max accepted", 32'(sub_ok), 1);
    chk("R3 slot", 32'(sub_slot), 1);
    eng_idx = 4'd1; #1;
    chk("R3 ctl max", eng_ctl, 32'hE100_05EA);
  endtask

  task automatic t_order();
    writeback(4'd1, 32'h0);
    idle(3);
    chk("R5 stall rm", 32'(rm_idx), 0);
    chk("R5 stall inflight", 32'(inflight), 2);
    writeback(4'd0, 32'h0);
    idle(3);
    chk("R5 drained rm", 32'(rm_idx), 2);
    chk("R5 drained inflight", 32'(inflight), 0);
  endtask

  task automatic t_skip_and_err();
    submit(14'd100);
    writeback(4'd2, 32'h7FFF_FFFF);
    idle(2);
    chk("R6 skip reclaimed", 32'(rm_idx), 3);
    chk("R6 no escalate", 32'(sf_mode), 0);
    submit(14'd100);
    writeback(4'd3, 32'h0000_4000);
    idle(2);
    chk("R8 reclaimed", 32'(rm_idx), 4);
    chk("R8 no escalate", 32'(sf_mode), 0);
  endtask

  task automatic t_fill_drain();
    for (int i = 0; i < 14; i++) submit(14'd60);
    chk("R2 inflight cap", 32'(inflight), 14);
    chk("R1 wrap slot", 32'(sub_slot), 1);
    chk("R1 wrap ins", 32'(ins_idx), 2);
    submit(14'd60);
    chk("R2 refuse full", 32'(sub_err), 1);
    chk("R2 ins held", 32'(ins_idx), 2);
    eng_idx = 4'd2; #1;
    chk("R2 no own", 32'(eng_own), 0);
    writeback(4'd4, 32'h0000_0002);
    for (int i = 5; i < 18; i++) writeback(4'(i), 32'h0);
    idle(2);
    chk("R7 escalate", 32'(sf_mode), 1);
    chk("R5 all reclaimed", 32'(inflight), 0);
    chk("R1 rm wrap", 32'(rm_idx), 2);
    submit(14'd60);
    writeback(4'd2, 32'h0);
    idle(2);
    chk("R7 sticky", 32'(sf_mode), 1);
  endtask

  task automatic t_reset_mid();
    submit(14'd80);
    do_reset();
    t_reset();
  endtask

  initial begin
    idle(3); rst_n = 1'b1;
    idle(1);
    t_reset();
    t_basic();
    t_length();
    t_order();
    t_skip_and_err();
    t_fill_drain();
    t_reset_mid();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule